// File: doc/BRIEF.md
# Wait-State Word Memory Responder

This block is the memory side of a simple single-master request bus. A requester asks for one access by raising either a read strobe or a write strobe for exactly one clock cycle, together with a byte address, a 32-bit write word and a per-byte write-enable mask. The responder holds its own word-organised RAM and answers after a fixed, parameterised number of wait states. While it works through a request it holds a registered busy line high. Read data is presented in a registered output once busy has fallen again.

The busy line is never combinational. It rises on the cycle after an accepted strobe and stays high for `WAIT_STATES` cycles. With zero wait states it never rises, and read data appears on the cycle after the strobe. A write only lands in the array at the end of its wait period, so a read issued in the first non-busy cycle already returns the new bytes. A requester that breaks the protocol trips a sticky error flag, and its request is dropped. Breaking the protocol means strobing while busy, or raising both strobes at once.

Top module: `mem_wait_responder`

## Requirements
- R1: After a synchronous reset, `rsp_busy` is 0, `proto_err` is 0 and `rsp_rdata` is 0.
- R2: With `WAIT_STATES` = N > 0, a request accepted in cycle T drives `rsp_busy` high in cycles T+1 through T+N and low in cycle T+N+1.
- R3: With `WAIT_STATES` = 0, `rsp_busy` never rises, and read data for a read strobed in cycle T is on `rsp_rdata` in cycle T+1.
- R4: `rsp_rdata` changes only on the completion of an accepted read. It holds its value across idle cycles and across writes.
- R5: On a write, the mask bit `req_bmask[i]` enables data bits [8i+7:8i]. Byte offset 0 (mask bit 3) is bits 31:24, and byte offset 3 (mask bit 0) is bits 7:0. Bytes whose mask bit is 0 keep their stored value.
- R6: A write is committed at the end of its wait period. A read strobed in the first cycle after busy falls returns the written bytes.
- R7: A strobe seen while `rsp_busy` is 1 is ignored: no access and no change to the memory. `proto_err` is 1 from the following cycle.
- R8: Both strobes high in one cycle are rejected: no access, busy stays low and memory is unchanged. `proto_err` is 1 from the following cycle.
- R9: `proto_err` stays 1 until reset.
- R10: The two low address bits are ignored. Word `req_addr[ADDR_W-1:2]` is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | One-cycle read strobe |
| req_wr | input | 1 | One-cycle write strobe |
| req_addr | input | ADDR_W | Byte address; low two bits ignored |
| req_wdata | input | 32 | Write word, sampled with the write strobe |
| req_bmask | input | 4 | Per-byte write enable, bit 3 = byte offset 0 (MSB) |
| rsp_busy | output | 1 | Registered busy, high during wait states |
| rsp_rdata | output | 32 | Registered read data |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
A countdown that stops one cycle early or late shows up as busy falling in the wrong cycle. A read that completes early would return the stale word from the previous read. Both are visible within the request's own window of N+1 cycles. A wrong pending-operation flag or latched index corrupts the array silently, so every write in the stimulus is followed by a read-back of the same word, with partial masks on both end bytes. The error latch is probed after an illegal strobe, after idle cycles and after reset, and an ignored request is confirmed by reading the word back.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int BYTES  = DATA_W / BYTE_W;
  localparam int OFF_W  = $clog2(BYTES);

  typedef enum logic [1:0] {
    REQ_NONE,
    REQ_READ,
    REQ_WRITE,
    REQ_BAD
  } req_kind_e;

  function automatic req_kind_e classify(input logic rd, input logic wr);
    case ({rd, wr})
      2'b10:   return REQ_READ;
      2'b01:   return REQ_WRITE;
      2'b11:   return REQ_BAD;
      default: return REQ_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mwr_req_ctrl.sv
module mwr_req_ctrl
  import mwr_pkg::*;
#(
  parameter int IDX_W       = 8,
  parameter int WAIT_STATES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BYTES-1:0]  wmask,
  output logic              busy,
  output logic              fire_rd,
  output logic              fire_wr,
  output logic [IDX_W-1:0]  fire_idx,
  output logic [DATA_W-1:0] fire_data,
  output logic [BYTES-1:0]  fire_mask
);
  req_kind_e kind;
  logic busy_q, set_busy, clr_busy, accept;

  assign kind   = classify(rd_en, wr_en);
  assign accept = (kind == REQ_READ || kind == REQ_WRITE) && !busy_q;
  assign busy   = busy_q;

  always_ff @(posedge clk) begin
    if (rst)           busy_q <= 1'b0;
    else if (set_busy) busy_q <= 1'b1;
    else if (clr_busy) busy_q <= 1'b0;
  end

  generate
    if (WAIT_STATES == 0) begin : g_direct
      // Accepted request goes straight to the array ports at this edge.
      assign set_busy  = 1'b0;
      assign clr_busy  = 1'b0;
      assign fire_rd   = accept && (kind == REQ_READ);
      assign fire_wr   = accept && (kind == REQ_WRITE);
      assign fire_idx  = idx_in;
      assign fire_data = wdata;
      assign fire_mask = wmask;
    end else begin : g_wait
      localparam int CNT_W = $clog2(WAIT_STATES + 1);
      logic [CNT_W-1:0]  cnt;
      logic              pend_rd, pend_wr, last;
      logic [IDX_W-1:0]  idx_q;
      logic [DATA_W-1:0] data_q;
      logic [BYTES-1:0]  mask_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt     <= '0;
          pend_rd <= 1'b0;
          pend_wr <= 1'b0;
        end else if (accept) begin
          cnt     <= CNT_W'(WAIT_STATES);
          pend_rd <= (kind == REQ_READ);
          pend_wr <= (kind == REQ_WRITE);
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end

      // Payload registers carry no reset so they map to plain flops.
      always_ff @(posedge clk) begin
        if (accept) begin
          idx_q  <= idx_in;
          data_q <= wdata;
          mask_q <= wmask;
        end
      end

      assign last      = (cnt == CNT_W'(1));
      assign set_busy  = accept;
      assign clr_busy  = last;
      assign fire_rd   = last && pend_rd;
      assign fire_wr   = last && pend_wr;
      assign fire_idx  = idx_q;
      assign fire_data = data_q;
      assign fire_mask = mask_q;

      p_busy_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_q);
      p_busy_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last) |=> busy_q);
      p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && last) |=> !busy_q);
      p_commit_at_end_r6: assert property (@(posedge clk) disable iff (rst)
        (fire_wr || fire_rd) |=> !busy_q);
    end
  endgenerate
endmodule

// File: rtl/mwr_byte_ram.sv
module mwr_byte_ram
  import mwr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_rd,
  input  logic              fire_wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  input  logic [BYTES-1:0]  mask,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  // One narrow array per byte lane: each maps to a RAM with a single write enable.
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] store [DEPTH];
    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (fire_wr && mask[b]) store[idx] <= data[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (fire_rd) q <= store[idx];
    end

    assign rdata[b*BYTE_W +: BYTE_W] = q;
  end

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !fire_rd |=> $stable(rdata));
endmodule

// File: rtl/mwr_violation_mon.sv
module mwr_violation_mon
  import mwr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic wr_en,
  input  logic busy,
  output logic err
);
  req_kind_e kind;
  logic      bad;

  assign kind = classify(rd_en, wr_en);
  assign bad  = (kind == REQ_BAD) || ((kind != REQ_NONE) && busy);

  always_ff @(posedge clk) begin
    if (rst)      err <= 1'b0;
    else if (bad) err <= 1'b1;
  end

  p_collision_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en) |=> err);
  p_busy_req_flag_r7: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && busy) |=> err);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/mem_wait_responder.sv
module mem_wait_responder
  import mwr_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int WAIT_STATES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_bmask,
  output logic              rsp_busy,
  output logic [31:0]       rsp_rdata,
  output logic              proto_err
);
  localparam int IDX_W = ADDR_W - OFF_W;

  logic              fire_rd, fire_wr;
  logic [IDX_W-1:0]  fire_idx;
  logic [DATA_W-1:0] fire_data;
  logic [BYTES-1:0]  fire_mask;
  logic              unused_low_bits;

  // Byte offset within the word does not select anything.
  assign unused_low_bits = ^req_addr[OFF_W-1:0];

  mwr_req_ctrl #(.IDX_W(IDX_W), .WAIT_STATES(WAIT_STATES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (req_rd),
    .wr_en     (req_wr),
    .idx_in    (req_addr[ADDR_W-1:OFF_W]),
    .wdata     (req_wdata),
    .wmask     (req_bmask),
    .busy      (rsp_busy),
    .fire_rd   (fire_rd),
    .fire_wr   (fire_wr),
    .fire_idx  (fire_idx),
    .fire_data (fire_data),
    .fire_mask (fire_mask)
  );

  mwr_byte_ram #(.IDX_W(IDX_W)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .fire_rd (fire_rd),
    .fire_wr (fire_wr),
    .idx     (fire_idx),
    .data    (fire_data),
    .mask    (fire_mask),
    .rdata   (rsp_rdata)
  );

  mwr_violation_mon u_mon (
    .clk   (clk),
    .rst   (rst),
    .rd_en (req_rd),
    .wr_en (req_wr),
    .busy  (rsp_busy),
    .err   (proto_err)
  );
endmodule

// File: tb/mem_wait_responder_bench.sv
module mem_wait_responder_bench;
  localparam int WS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        m_rd = 0, m_wr = 0;
  logic [9:0]  m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic [3:0]  m_mask = '0;
  logic        m_busy, m_err;
  logic [31:0] m_rdata;

  logic        z_rd = 0, z_wr = 0;
  logic [9:0]  z_addr = '0;
  logic [31:0] z_wdata = '0;
  logic [3:0]  z_mask = '0;
  logic        z_busy, z_err;
  logic [31:0] z_rdata;

  int checks = 0;
  int fails  = 0;

  mem_wait_responder #(.ADDR_W(10), .WAIT_STATES(WS)) u_mem_wait_responder (
    .clk(clk), .rst(rst), .req_rd(m_rd), .req_wr(m_wr), .req_addr(m_addr),
    .req_wdata(m_wdata), .req_bmask(m_mask), .rsp_busy(m_busy),
    .rsp_rdata(m_rdata), .proto_err(m_err));

  mem_wait_responder #(.ADDR_W(10), .WAIT_STATES(0)) u_mem_wait_responder_ws0 (
    .clk(clk), .rst(rst), .req_rd(z_rd), .req_wr(z_wr), .req_addr(z_addr),
    .req_wdata(z_wdata), .req_bmask(z_mask), .rsp_busy(z_busy),
    .rsp_rdata(z_rdata), .proto_err(z_err));

  // {is_write, addr, wdata, mask, expected read word}
  localparam logic [78:0] VECS [0:11] = '{
    {1'b1, 10'h000, 32'h11223344, 4'hF, 32'h0},
    {1'b0, 10'h000, 32'h0,        4'h0, 32'h11223344},
    {1'b1, 10'h004, 32'hDEADBEEF, 4'hF, 32'h0},
    {1'b1, 10'h004, 32'hAABBCCDD, 4'h8, 32'h0},
    {1'b0, 10'h004, 32'h0,        4'h0, 32'hAAADBEEF},
    {1'b1, 10'h004, 32'h00000055, 4'h1, 32'h0},
    {1'b0, 10'h006, 32'h0,        4'h0, 32'hAAADBE55},
    {1'b1, 10'h3FC, 32'hCAFEF00D, 4'hF, 32'h0},
    {1'b0, 10'h3FF, 32'h0,        4'h0, 32'hCAFEF00D},
    {1'b1, 10'h008, 32'h00000000, 4'hF, 32'h0},
    {1'b1, 10'h008, 32'h12345678, 4'h6, 32'h0},
    {1'b0, 10'h008, 32'h0,        4'h0, 32'h00345600}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge of the first non-busy cycle.
  task automatic main_req(input bit rd, input bit wr, input logic [9:0] a,
                          input logic [31:0] d, input logic [3:0] m,
                          input logic [31:0] exp, input string tag);
    m_rd = rd; m_wr = wr; m_addr = a; m_wdata = d; m_mask = m;
    @(negedge clk);
    m_rd = 0; m_wr = 0; m_wdata = 32'hFFFF_FFFF;
    chk("R2 busy rises", 32'(m_busy), 32'd1);
    for (int k = 1; k < WS; k++) begin
      @(negedge clk);
      chk("R2 busy held", 32'(m_busy), 32'd1);
    end
    @(negedge clk);
    chk("R2 busy falls", 32'(m_busy), 32'd0);
    if (rd) chk(tag, m_rdata, exp);
  endtask

  task automatic zero_req(input bit rd, input bit wr, input logic [9:0] a,
                          input logic [31:0] d, input logic [3:0] m,
                          input logic [31:0] exp);
    z_rd = rd; z_wr = wr; z_addr = a; z_wdata = d; z_mask = m;
    @(negedge clk);
    z_rd = 0; z_wr = 0;
    chk("R3 no busy", 32'(z_busy), 32'd0);
    if (rd) chk("R3 read next cycle", z_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 busy", 32'(m_busy), 32'd0);
    chk("R1 err", 32'(m_err), 32'd0);
    chk("R1 rdata", m_rdata, 32'd0);
    chk("R1 ws0 rdata", z_rdata, 32'd0);

    foreach (VECS[i]) begin
      main_req(!VECS[i][78], VECS[i][78], VECS[i][77:68], VECS[i][67:36],
               VECS[i][35:32], VECS[i][31:0], "R5 R6 R10 readback");
    end
    chk("R7 no false error", 32'(m_err), 32'd0);

    // R4: rdata holds across idle cycles and writes
    repeat (3) @(negedge clk);
    chk("R4 hold idle", m_rdata, 32'h00345600);
    main_req(0, 1, 10'h00C, 32'h77777777, 4'hF, 32'h0, "R4");
    chk("R4 hold over write", m_rdata, 32'h00345600);

    // R7: strobe while busy is dropped and flagged
    m_wr = 1; m_addr = 10'h000; m_wdata = 32'h0; m_mask = 4'hF;
    @(negedge clk);
    m_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    m_wr = 0;
    chk("R7 err set", 32'(m_err), 32'd1);
    chk("R7 still busy", 32'(m_busy), 32'd1);
    repeat (2) @(negedge clk);
    chk("R7 busy done", 32'(m_busy), 32'd0);
    main_req(1, 0, 10'h000, 32'h0, 4'h0, 32'h0, "R7 ignored write");

    // R9: sticky until reset
    repeat (5) @(negedge clk);
    chk("R9 err sticky", 32'(m_err), 32'd1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R9 err cleared by reset", 32'(m_err), 32'd0);

    // R8: collision
    m_rd = 1; m_wr = 1; m_addr = 10'h000; m_wdata = 32'h5; m_mask = 4'hF;
    @(negedge clk);
    m_rd = 0; m_wr = 0;
    chk("R8 no busy", 32'(m_busy), 32'd0);
    chk("R8 err set", 32'(m_err), 32'd1);
    main_req(1, 0, 10'h000, 32'h0, 4'h0, 32'h0, "R8 memory unchanged");

    // R3: zero wait states
    zero_req(0, 1, 10'h010, 32'h0BADF00D, 4'hF, 32'h0);
    zero_req(1, 0, 10'h010, 32'h0, 4'h0, 32'h0BADF00D);
    zero_req(0, 1, 10'h011, 32'h0000AA00, 4'h2, 32'h0);
    zero_req(1, 0, 10'h012, 32'h0, 4'h0, 32'h0BADAA0D);
    chk("R3 ws0 no error", 32'(z_err), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule